// File: doc/BRIEF.md
# Exception-Return Target ALU

This block produces the branch target of an exception-return data-processing operation. A 4-bit operation code selects one of twelve bitwise or arithmetic operations. The operation combines a first operand with a second operand. The second operand is either an already shifted register value or a small immediate, zero-extended to the full width. Every arithmetic operation goes through one shared add-with-carry datapath. Its carry-out and overflow are dropped, and no condition flags are produced from the result.

When an operation is accepted and its condition holds, the block does two things on the following cycle. It strobes the result into the program counter, and it strobes a copy of the saved status word into the current status word with every byte lane enabled. Two kinds of operation raise an error flag and suppress both strobes:

- an operation issued in the restricted execution state;
- an operation whose code falls in the unused range.

When the condition fails, nothing is written.

The load-link-register-into-PC-with-flags alias needs no special handling. It is issued as a subtract with an immediate of zero, so the target equals the first operand.

Top module: `xret_alu`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `target`, `pc_wr`, `psr_restore` and `err` are all zero.
- R2: Bitwise codes produce the following results one cycle after an accepted pulse:
  - 4'b0000 gives A AND B.
  - 4'b0001 gives A XOR B.
  - 4'b1100 gives A OR B.
  - 4'b1110 gives A AND NOT B.
- R3: Code 4'b1101 gives B unchanged, and code 4'b1111 gives NOT B.
- R4: Fixed-carry arithmetic works modulo 2^32, with the carry-out discarded:
  - 4'b0010 gives A - B.
  - 4'b0011 gives B - A.
  - 4'b0100 gives A + B.
- R5: Carry-flag arithmetic uses the current carry flag C, modulo 2^32:
  - 4'b0101 gives A + B + C.
  - 4'b0110 gives A - B - 1 + C.
  - 4'b0111 gives B - A - 1 + C.
- R6: With `use_imm`=1, B is `imm` zero-extended to 32 bits. With `use_imm`=0, B is `op_b_reg`.
- R7: When `in_valid`=1 and `cond_ok`=1, with a legal code outside the restricted state, `pc_wr` and `psr_restore` are both 1 on the next cycle and `err` is 0.
- R8: When `in_valid`=1 and `cond_ok`=0, `pc_wr`, `psr_restore` and `err` are all 0 on the next cycle.
- R9: When `in_valid`=1, `cond_ok`=1 and `restricted`=1, `err` is 1 on the next cycle, and `pc_wr` and `psr_restore` are 0.
- R10: Codes 4'b1000 to 4'b1011 with `cond_ok`=1 set `err` on the next cycle and keep both strobes at 0.
- R11: A cycle with `in_valid`=0 leaves all three flags at 0 on the next cycle, and `target` keeps its value.
- R12: Code 4'b0010 with `use_imm`=1 and `imm`=0 returns `op_a` unchanged as the target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle pulse presenting an operation |
| cond_ok | input | 1 | Condition check for this operation passed |
| restricted | input | 1 | Core is in the restricted execution state |
| opcode | input | 4 | Operation code |
| op_a | input | 32 | First operand |
| op_b_reg | input | 32 | Shifted register form of the second operand |
| imm | input | 8 | Immediate form of the second operand |
| use_imm | input | 1 | Select the immediate as second operand |
| carry_flag | input | 1 | Current carry flag |
| target | output | 32 | Registered branch target |
| pc_wr | output | 1 | Program-counter write strobe |
| psr_restore | output | 1 | Saved-to-current status copy strobe, all byte lanes |
| err | output | 1 | Illegal restricted-state or unused-code operation |

## Verification
The assertions check the control rules on every cycle:
- a failed condition, the restricted state and the unused codes each keep both write strobes low;
- a flag never appears without a pulse on the cycle before;
- the pass-through code and the zero-immediate subtract both return the expected operand.

The arithmetic and bitwise results of all twelve codes can only be shown by the bench's sweep. It covers both operand sources, both carry values and operand patterns that hit wrap-around at every bit width.

// File: rtl/xret_pkg.sv
`timescale 1ns/1ps
package xret_pkg;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_AND  = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_XOR  = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_SUB  = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_RSUB = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_ADD  = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_ADDC = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_SUBC = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_RSBC = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_OR   = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_PASS = 4'b1101;
    localparam logic [OPC_W-1:0] OPC_CLR  = 4'b1110;
    localparam logic [OPC_W-1:0] OPC_INV  = 4'b1111;

    // Codes 10xx are unused for this operation.
    function automatic logic opc_unused(input logic [OPC_W-1:0] o);
        return o[3:2] == 2'b10;
    endfunction

    // Codes 0010..0111 go through the adder.
    function automatic logic opc_arith(input logic [OPC_W-1:0] o);
        return (o[3] == 1'b0) && (o[2:1] != 2'b00);
    endfunction
endpackage

// File: rtl/xret_operand_sel.sv
`timescale 1ns/1ps
module xret_operand_sel #(
    parameter int W     = 32,
    parameter int IMM_W = 8
) (
    input  logic             use_imm,
    input  logic [W-1:0]     reg_val,
    input  logic [IMM_W-1:0] imm_val,
    output logic [W-1:0]     opnd
);
    localparam int PAD_W = W - IMM_W;

    always_comb begin
        if (use_imm) opnd = {{PAD_W{1'b0}}, imm_val};
        else         opnd = reg_val;
    end
endmodule

// File: rtl/xret_logic_unit.sv
`timescale 1ns/1ps
module xret_logic_unit
    import xret_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     y
);
    always_comb begin
        unique case (opc)
            OPC_AND:  y = a & b;
            OPC_XOR:  y = a ^ b;
            OPC_OR:   y = a | b;
            OPC_PASS: y = b;
            OPC_CLR:  y = a & ~b;
            OPC_INV:  y = ~b;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/xret_adder.sv
`timescale 1ns/1ps
module xret_adder #(
    parameter int W = 32
) (
    input  logic [2:0]   sel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cflag,
    output logic [W-1:0] sum
);
    logic inv_a_d, inv_b_d, cin_d;
    logic [W-1:0] a_op, b_op;

    always_comb begin
        inv_a_d = (sel[1:0] == 2'b11);          // reverse forms
        inv_b_d = (sel[1:0] == 2'b10);          // subtract forms
        if (sel[2] == 1'b0) cin_d = 1'b1;       // SUB, RSUB
        else if (sel[1:0] == 2'b00) cin_d = 1'b0; // ADD
        else cin_d = cflag;                     // carry-using forms
        a_op = inv_a_d ? ~a : a;
        b_op = inv_b_d ? ~b : b;
        sum  = a_op + b_op + {{(W-1){1'b0}}, cin_d};
    end
endmodule

// File: rtl/xret_alu.sv
`timescale 1ns/1ps
module xret_alu
    import xret_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              cond_ok,
    input  logic              restricted,
    input  logic [3:0]        opcode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              carry_flag,
    output logic [DATA_W-1:0] target,
    output logic              pc_wr,
    output logic              psr_restore,
    output logic              err
);
    typedef struct packed {
        logic [DATA_W-1:0] target;
        logic              pc_wr;
        logic              psr_wr;
        logic              err;
    } xret_state_t;

    xret_state_t st_d, st_q;
    logic [DATA_W-1:0] opnd_b, log_y, add_y;

    xret_operand_sel #(.W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .use_imm(use_imm), .reg_val(op_b_reg), .imm_val(imm), .opnd(opnd_b)
    );

    xret_logic_unit #(.W(DATA_W)) u_log (
        .opc(opcode), .a(op_a), .b(opnd_b), .y(log_y)
    );

    xret_adder #(.W(DATA_W)) u_add (
        .sel(opcode[2:0]), .a(op_a), .b(opnd_b), .cflag(carry_flag), .sum(add_y)
    );

    always_comb begin
        st_d        = st_q;
        st_d.pc_wr  = 1'b0;
        st_d.psr_wr = 1'b0;
        st_d.err    = 1'b0;
        if (in_valid) begin
            st_d.target = opc_arith(opcode) ? add_y : log_y;
            if (cond_ok) begin
                if (restricted || opc_unused(opcode)) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.pc_wr  = 1'b1;
                    st_d.psr_wr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign target      = st_q.target;
    assign pc_wr       = st_q.pc_wr;
    assign psr_restore = st_q.psr_wr;
    assign err         = st_q.err;

    p_cond_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_ok) |=> (!pc_wr && !psr_restore && !err));

    p_restricted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_ok && restricted) |=> (err && !pc_wr && !psr_restore));

    p_unused_opc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_ok && opcode[3:2] == 2'b10) |=> (err && !pc_wr && !psr_restore));

    p_strobe_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_ok && !restricted && opcode[3:2] != 2'b10)
            |=> (pc_wr && psr_restore && !err));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!pc_wr && !psr_restore && !err && $stable(target)));

    p_pass_imm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'b1101 && use_imm)
            |=> (target == {{(DATA_W-IMM_W){1'b0}}, $past(imm)}));

    p_sub_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 4'b0010 && use_imm && imm == '0)
            |=> (target == $past(op_a)));
endmodule

// File: tb/sim_xret_alu.sv
`timescale 1ns/1ps
module sim_xret_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, cond_ok = 1'b0, restricted = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] op_a = '0, op_b_reg = '0;
    logic [7:0]  imm = '0;
    logic        use_imm = 1'b0, carry_flag = 1'b0;
    logic [31:0] target;
    logic        pc_wr, psr_restore, err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xret_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_ok(cond_ok),
        .restricted(restricted), .opcode(opcode), .op_a(op_a), .op_b_reg(op_b_reg),
        .imm(imm), .use_imm(use_imm), .carry_flag(carry_flag),
        .target(target), .pc_wr(pc_wr), .psr_restore(psr_restore), .err(err)
    );

    localparam logic [31:0] PAT [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000,
                                        32'h1234_5678, 32'h7FFF_FF01, 32'h0000_00FF};

    function automatic logic [31:0] ref_res(input logic [3:0] o, input logic [31:0] a,
                                            input logic [31:0] b, input logic c);
        case (o)
            4'd0:  return a & b;
            4'd1:  return a ^ b;
            4'd2:  return a - b;
            4'd3:  return b - a;
            4'd4:  return a + b;
            4'd5:  return a + b + {31'b0, c};
            4'd6:  return a - b - 32'd1 + {31'b0, c};
            4'd7:  return b - a - 32'd1 + {31'b0, c};
            4'd12: return a | b;
            4'd13: return b;
            4'd14: return a & ~b;
            4'd15: return ~b;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] o);
        if (o == 4'd0 || o == 4'd1 || o == 4'd12 || o == 4'd14) return "R2";
        if (o == 4'd13 || o == 4'd15) return "R3";
        if (o >= 4'd2 && o <= 4'd4) return "R4";
        if (o >= 4'd5 && o <= 4'd7) return "R5";
        return "R10";
    endfunction

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got target=%h pc_wr=%b psr=%b err=%b, expected target=%h pc_wr=%b psr=%b err=%b",
                     req, act[34:3], act[2], act[1], act[0], exp[34:3], exp[2], exp[1], exp[0]);
        end
    endtask

    // Drive one pulse at a falling edge, sample at the next falling edge.
    task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] br,
                          input logic [7:0] im, input logic ui, input logic c,
                          input logic cnd, input logic rs, input string req);
        logic [31:0] b;
        logic [31:0] exp_t;
        b = ui ? {24'h0, im} : br;
        opcode = o; op_a = a; op_b_reg = br; imm = im; use_imm = ui;
        carry_flag = c; cond_ok = cnd; restricted = rs; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (!cnd)
            check(req, {target, pc_wr, psr_restore, err}, {target, 3'b000});
        else if (rs || o[3:2] == 2'b10)
            check(req, {target, pc_wr, psr_restore, err}, {target, 3'b001});
        else begin
            exp_t = ref_res(o, a, b, c);
            check(req, {target, pc_wr, psr_restore, err}, {exp_t, 3'b110});
        end
    endtask

    initial begin
        logic [31:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {target, pc_wr, psr_restore, err}, 35'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {target, pc_wr, psr_restore, err}, 35'h0);

        // Sweep of all codes, operand patterns, carry values and operand sources (R2-R7, R10)
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int c = 0; c < 2; c++)
                        for (int u = 0; u < 2; u++)
                            run_op(4'(o), PAT[i], PAT[j] ^ 32'h0F0F_0000, PAT[j][7:0] ^ 8'h3C,
                                   1'(u), 1'(c), 1'b1, 1'b0,
                                   u == 1 ? {req_of(4'(o)), " R6 R7"} : {req_of(4'(o)), " R7"});

        // R6: operand source selection with differing register and immediate values
        run_op(4'd13, 32'h0, 32'hDEAD_BEEF, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
        run_op(4'd13, 32'h0, 32'hDEAD_BEEF, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, "R6");

        // R8: condition failed, nothing written, across several codes
        for (int o = 0; o < 16; o++)
            run_op(4'(o), 32'h1111_2222, 32'h3333_4444, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        run_op(4'd2, 32'h1, 32'h0, 8'h0, 1'b1, 1'b0, 1'b0, 1'b1, "R8");

        // R9: restricted state raises error, no strobes
        for (int o = 0; o < 16; o++)
            run_op(4'(o), 32'hCAFE_0000, 32'h0000_0010, 8'h10, 1'b0, 1'b0, 1'b1, 1'b1, "R9");

        // R10: unused codes
        for (int o = 8; o < 12; o++)
            run_op(4'(o), 32'h5, 32'h6, 8'h7, 1'b1, 1'b1, 1'b1, 1'b0, "R10");

        // R12: zero-immediate subtract returns the first operand
        run_op(4'd2, 32'h8000_1234, 32'hFFFF_FFFF, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, "R12");
        run_op(4'd2, 32'hFFFF_FFFE, 32'h0000_0001, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, "R12");

        // R11: idle cycles keep flags low and target held
        run_op(4'd4, 32'h0000_1000, 32'h0000_0234, 8'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        held = target;
        opcode = 4'd15; op_a = 32'hFFFF_FFFF; op_b_reg = 32'h0; cond_ok = 1'b1;
        @(negedge clk);
        check("R11", {target, pc_wr, psr_restore, err}, {held, 3'b000});
        @(negedge clk);
        check("R11", {target, pc_wr, psr_restore, err}, {held, 3'b000});

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule